// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small 8-bit accumulator machine. One operand is the accumulator value and the other is a memory operand or an immediate. A 4-bit mode selects one of sixteen operations: addition, subtraction in either direction, pass-through of either operand, bitwise logic, increment, decrement, rotates, logical and arithmetic shifts, and negation. Alongside the result, the block produces the next value of the four status flags.

The surrounding machine loads the flags output into its status register and the result into the accumulator or into memory. Each operation changes only its own set of flags. Every other flag is passed through from the current-flags input, so the status register can be loaded on every ALU instruction without extra masking. A shift or rotate takes its amount from the low three bits of the accumulator operand.

Top module: `acc_alu`

## Requirements
- R1: The flags output is ordered, from bit 3 down to bit 0, as zero (Z), carry (C), sign (S) and overflow (O). When an operation updates Z, Z is 1 exactly when the 8-bit result is zero. When an operation updates S, S equals result bit 7.
- R2: Mode 0 gives accumulator plus operand. Mode 1 gives accumulator minus operand. Mode 7 gives operand minus accumulator. These modes update all four flags. C is the unsigned carry out for addition, and it means "no borrow" (minuend >= subtrahend, unsigned) for subtraction. O is signed two's-complement overflow.
- R3: Mode 8 gives operand plus 1, mode 9 gives operand minus 1 and mode F gives 0 minus operand. All three update all four flags. C is 1 for increment of 0xFF, for decrement of any nonzero value, and for negation of 0x00. O is 1 for increment of 0x7F and for decrement or negation of 0x80.
- R4: Mode 2 passes the accumulator and mode 3 passes the operand. Neither changes any flag.
- R5: Modes 4, 5 and 6 give bitwise AND, OR and XOR of the two operands. They update Z only, and C, S and O pass through.
- R6: Mode A rotates the operand left and mode B rotates it right, by accumulator[2:0] bit positions. No flag changes.
- R7: Mode C shifts the operand left and mode D shifts it right, both logically with zero fill, by accumulator[2:0]. They update Z, and C takes the last bit shifted out. S and O pass through.
- R8: Mode E shifts the operand right arithmetically by accumulator[2:0], filling with the original bit 7. It updates Z, S, and C (the last bit shifted out). O passes through.
- R9: In modes C, D and E, a shift amount of zero gives the operand unchanged and leaves Z and C at their incoming values. Mode E still updates S.
- R10: With the enable low, the result is 0x00 and the flags output equals the flags input, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| accIn | input | 8 | First operand (accumulator); bits 2:0 give the shift or rotate amount |
| operandIn | input | 8 | Second operand (memory data or immediate) |
| aluMode | input | 4 | Operation select, codes 0 to F |
| aluEnable | input | 1 | When low, the result is zero and the flags pass through |
| flagsIn | input | 4 | Current flags {Z,C,S,O} |
| aluResult | output | 8 | Operation result |
| flagsOut | output | 4 | Next flags {Z,C,S,O} |

## Verification
The unit holds no state, so any fault in its decode or datapath appears on the ports in the same evaluation as the inputs that expose it. Nothing can hide a fault across cycles. A wrong strobe from the mode decoder shows as a flag that moves when it should be held, or that is held when it should move. The bench therefore seeds the incoming flags with values opposite to the expected new ones, so that a missed pass-through or a wrongly masked flag becomes visible. Zero shift amounts, signed overflow edges and carry out of the final shifted bit are driven on purpose, because most wrong carry or hold logic can only be seen with those inputs.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int ModeBits = 4;

  typedef enum logic [ModeBits-1:0] {
    MODE_ADD    = 4'h0,
    MODE_SUB_AB = 4'h1,
    MODE_PASS_A = 4'h2,
    MODE_PASS_B = 4'h3,
    MODE_AND    = 4'h4,
    MODE_OR     = 4'h5,
    MODE_XOR    = 4'h6,
    MODE_SUB_BA = 4'h7,
    MODE_INC_B  = 4'h8,
    MODE_DEC_B  = 4'h9,
    MODE_ROL    = 4'hA,
    MODE_ROR    = 4'hB,
    MODE_SLL    = 4'hC,
    MODE_SRL    = 4'hD,
    MODE_SRA    = 4'hE,
    MODE_NEG    = 4'hF
  } aluMode_e;

  // Adder input selection
  typedef enum logic [1:0] {X_ZERO, X_A, X_B} addX_e;
  typedef enum logic [2:0] {Y_ZERO, Y_B, Y_NOT_B, Y_NOT_A, Y_ONES} addY_e;

  // Result source
  typedef enum logic [3:0] {
    R_SUM, R_A, R_B, R_AND, R_OR, R_XOR, R_ROL, R_ROR, R_SLL, R_SRL, R_SRA
  } resSel_e;

  // Carry source
  typedef enum logic [1:0] {C_ADD, C_LEFT, C_RIGHT} carrySel_e;

  // Flags in Z,C,S,O order (Z is the MSB)
  typedef struct packed {
    logic z;
    logic c;
    logic s;
    logic o;
  } aluFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    addX_e     xSel;
    addY_e     ySel;
    logic      carryIn;
    resSel_e   resSel;
    carrySel_e carrySel;
    logic      updZ;
    logic      updC;
    logic      updS;
    logic      updO;
    logic      zeroAmtHold;
  } aluCtrl_t;

endpackage

// File: rtl/acc_alu_control.sv
module acc_alu_control
  import acc_alu_pkg::*;
(
  input  logic [ModeBits-1:0] aluMode,
  output aluCtrl_t            ctrl
);

  always_comb begin
    ctrl = '{xSel: X_ZERO, ySel: Y_ZERO, carryIn: 1'b0, resSel: R_SUM,
             carrySel: C_ADD, updZ: 1'b0, updC: 1'b0, updS: 1'b0,
             updO: 1'b0, zeroAmtHold: 1'b0};
    case (aluMode_e'(aluMode))
      MODE_ADD, MODE_SUB_AB, MODE_SUB_BA,
      MODE_INC_B, MODE_DEC_B, MODE_NEG: begin
        ctrl.resSel = R_SUM;
        ctrl.carrySel = C_ADD;
        ctrl.updZ = 1'b1;
        ctrl.updC = 1'b1;
        ctrl.updS = 1'b1;
        ctrl.updO = 1'b1;
        case (aluMode_e'(aluMode))
          MODE_ADD:    begin ctrl.xSel = X_A;    ctrl.ySel = Y_B;                            end
          MODE_SUB_AB: begin ctrl.xSel = X_A;    ctrl.ySel = Y_NOT_B; ctrl.carryIn = 1'b1;   end
          MODE_SUB_BA: begin ctrl.xSel = X_B;    ctrl.ySel = Y_NOT_A; ctrl.carryIn = 1'b1;   end
          MODE_INC_B:  begin ctrl.xSel = X_B;    ctrl.ySel = Y_ZERO;  ctrl.carryIn = 1'b1;   end
          MODE_DEC_B:  begin ctrl.xSel = X_B;    ctrl.ySel = Y_ONES;                         end
          default:     begin ctrl.xSel = X_ZERO; ctrl.ySel = Y_NOT_B; ctrl.carryIn = 1'b1;   end
        endcase
      end
      MODE_PASS_A: ctrl.resSel = R_A;
      MODE_PASS_B: ctrl.resSel = R_B;
      MODE_AND:    begin ctrl.resSel = R_AND; ctrl.updZ = 1'b1; end
      MODE_OR:     begin ctrl.resSel = R_OR;  ctrl.updZ = 1'b1; end
      MODE_XOR:    begin ctrl.resSel = R_XOR; ctrl.updZ = 1'b1; end
      MODE_ROL:    ctrl.resSel = R_ROL;
      MODE_ROR:    ctrl.resSel = R_ROR;
      MODE_SLL: begin
        ctrl.resSel = R_SLL;
        ctrl.carrySel = C_LEFT;
        ctrl.updZ = 1'b1;
        ctrl.updC = 1'b1;
        ctrl.zeroAmtHold = 1'b1;
      end
      MODE_SRL: begin
        ctrl.resSel = R_SRL;
        ctrl.carrySel = C_RIGHT;
        ctrl.updZ = 1'b1;
        ctrl.updC = 1'b1;
        ctrl.zeroAmtHold = 1'b1;
      end
      default: begin  // MODE_SRA
        ctrl.resSel = R_SRA;
        ctrl.carrySel = C_RIGHT;
        ctrl.updZ = 1'b1;
        ctrl.updC = 1'b1;
        ctrl.updS = 1'b1;
        ctrl.zeroAmtHold = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  input  logic             enable,
  input  aluFlags_t        flagsIn,
  output logic [WIDTH-1:0] result,
  output aluFlags_t        flagsOut
);

  localparam int Msb = WIDTH - 1;
  localparam int AmtBits = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [AmtBits-1:0] amt;
  assign amt = opA[AmtBits-1:0];

  // Shared adder
  logic [WIDTH-1:0] addX, addY;
  logic [WIDTH:0]   sumWide;
  logic             addOvf;

  always_comb begin
    case (ctrl.xSel)
      X_A:     addX = opA;
      X_B:     addX = opB;
      default: addX = '0;
    endcase
    case (ctrl.ySel)
      Y_B:     addY = opB;
      Y_NOT_B: addY = ~opB;
      Y_NOT_A: addY = ~opA;
      Y_ONES:  addY = '1;
      default: addY = '0;
    endcase
  end

  assign sumWide = {1'b0, addX} + {1'b0, addY} + {{WIDTH{1'b0}}, ctrl.carryIn};
  assign addOvf  = (addX[Msb] == addY[Msb]) && (sumWide[Msb] != addX[Msb]);

  // Rotators over a doubled operand
  logic [2*WIDTH-1:0] rolWide, rorWide;
  assign rolWide = {opB, opB} << amt;
  assign rorWide = {opB, opB} >> amt;

  // Shifters carry one extra bit that catches the last bit shifted out
  logic [WIDTH:0] sllWide, srlWide, sraWide;
  assign sllWide = {1'b0, opB} << amt;
  assign srlWide = {opB, 1'b0} >> amt;
  assign sraWide = $unsigned($signed({opB, 1'b0}) >>> amt);

  logic [WIDTH-1:0] rawRes;
  logic             rawC;

  always_comb begin
    case (ctrl.resSel)
      R_SUM:   rawRes = sumWide[WIDTH-1:0];
      R_A:     rawRes = opA;
      R_B:     rawRes = opB;
      R_AND:   rawRes = opA & opB;
      R_OR:    rawRes = opA | opB;
      R_XOR:   rawRes = opA ^ opB;
      R_ROL:   rawRes = rolWide[2*WIDTH-1:WIDTH];
      R_ROR:   rawRes = rorWide[WIDTH-1:0];
      R_SLL:   rawRes = sllWide[WIDTH-1:0];
      R_SRL:   rawRes = srlWide[WIDTH:1];
      R_SRA:   rawRes = sraWide[WIDTH:1];
      default: rawRes = '0;
    endcase
    case (ctrl.carrySel)
      C_LEFT:  rawC = sllWide[WIDTH];
      C_RIGHT: rawC = srlWide[0];
      default: rawC = sumWide[WIDTH];
    endcase
  end

  logic holdZc;
  assign holdZc = ctrl.zeroAmtHold && (amt == '0);

  always_comb begin
    result   = enable ? rawRes : '0;
    flagsOut = flagsIn;
    if (enable) begin
      if (ctrl.updZ && !holdZc) flagsOut.z = (rawRes == '0);
      if (ctrl.updC && !holdZc) flagsOut.c = rawC;
      if (ctrl.updS)            flagsOut.s = rawRes[Msb];
      if (ctrl.updO)            flagsOut.o = addOvf;
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]    accIn,
  input  logic [WIDTH-1:0]    operandIn,
  input  logic [ModeBits-1:0] aluMode,
  input  logic                aluEnable,
  input  logic [3:0]          flagsIn,
  output logic [WIDTH-1:0]    aluResult,
  output logic [3:0]          flagsOut
);

  aluCtrl_t  ctrl;
  aluFlags_t nextFlags;

  acc_alu_control u_ctrl (
    .aluMode (aluMode),
    .ctrl    (ctrl)
  );

  acc_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (accIn),
    .opB      (operandIn),
    .ctrl     (ctrl),
    .enable   (aluEnable),
    .flagsIn  (aluFlags_t'(flagsIn)),
    .result   (aluResult),
    .flagsOut (nextFlags)
  );

  assign flagsOut = nextFlags;

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] accIn,
  input logic [WIDTH-1:0] operandIn,
  input logic [3:0]       aluMode,
  input logic             aluEnable,
  input logic [3:0]       flagsIn,
  input logic [WIDTH-1:0] aluResult,
  input logic [3:0]       flagsOut
);

  localparam int AmtBits = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic known;
  assign known = !$isunknown({accIn, operandIn, aluMode, aluEnable, flagsIn,
                              aluResult, flagsOut});

  always_comb begin
    if (known) begin
      if (!aluEnable) begin
        a_r10_disabled_quiet: assert (aluResult == '0 && flagsOut == flagsIn)
          else $error("R10 disabled output not quiet");
      end else begin
        case (aluMode)
          4'h0, 4'h1, 4'h7, 4'h8, 4'h9, 4'hF: begin
            a_r1_zero_sign_track: assert (flagsOut[3] == (aluResult == '0) &&
                                          flagsOut[1] == aluResult[WIDTH-1])
              else $error("R1 Z/S do not track result");
          end
          4'h2, 4'h3: begin
            a_r4_pass_keeps_flags: assert (flagsOut == flagsIn &&
                aluResult == (aluMode == 4'h2 ? accIn : operandIn))
              else $error("R4 pass-through disturbed");
          end
          4'h4, 4'h5, 4'h6: begin
            a_r5_logic_only_zero: assert (flagsOut[2:0] == flagsIn[2:0])
              else $error("R5 logic op touched C/S/O");
          end
          4'hA, 4'hB: begin
            a_r6_rotate_quiet: assert (flagsOut == flagsIn &&
                $countones(aluResult) == $countones(operandIn))
              else $error("R6 rotate changed flags or bit count");
          end
          4'hC, 4'hD: begin
            a_r7_shift_keeps_so: assert (flagsOut[1:0] == flagsIn[1:0])
              else $error("R7 logical shift touched S/O");
          end
          default: begin
            if (aluMode == 4'hE) begin
              a_r8_sra_keeps_sign: assert (aluResult[WIDTH-1] == operandIn[WIDTH-1] &&
                                           flagsOut[0] == flagsIn[0])
                else $error("R8 arithmetic shift lost sign or touched O");
            end
          end
        endcase
        if ((aluMode == 4'hC || aluMode == 4'hD || aluMode == 4'hE) &&
            accIn[AmtBits-1:0] == '0) begin
          a_r9_zero_amount_hold: assert (aluResult == operandIn &&
                                         flagsOut[3:2] == flagsIn[3:2])
            else $error("R9 zero shift amount changed result or Z/C");
        end
      end
    end
  end

endmodule

bind acc_alu acc_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .accIn     (accIn),
  .operandIn (operandIn),
  .aluMode   (aluMode),
  .aluEnable (aluEnable),
  .flagsIn   (flagsIn),
  .aluResult (aluResult),
  .flagsOut  (flagsOut)
);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic [7:0] accIn, operandIn, aluResult;
  logic [3:0] aluMode, flagsIn, flagsOut;
  logic       aluEnable;

  acc_alu dut (
    .accIn     (accIn),
    .operandIn (operandIn),
    .aluMode   (aluMode),
    .aluEnable (aluEnable),
    .flagsIn   (flagsIn),
    .aluResult (aluResult),
    .flagsOut  (flagsOut)
  );

  typedef struct {
    string      req;
    logic [7:0] a;
    logic [7:0] b;
    logic [3:0] mode;
    logic [7:0] expRes;
    logic [3:0] expFlags;
  } item_t;

  item_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  function automatic string reqOf(logic [3:0] m, logic en, logic [7:0] a);
    if (!en) return "R10";
    if ((m == 4'hC || m == 4'hD || m == 4'hE) && a[2:0] == 3'd0) return "R9";
    case (m)
      4'h0, 4'h1, 4'h7: return "R2";
      4'h8, 4'h9, 4'hF: return "R3";
      4'h2, 4'h3:       return "R4";
      4'h4, 4'h5, 4'h6: return "R5";
      4'hA, 4'hB:       return "R6";
      4'hC, 4'hD:       return "R7";
      default:          return "R8";
    endcase
  endfunction

  // Independent reference: integer arithmetic and bit-at-a-time shifting
  function automatic logic [11:0] model(logic [7:0] a, logic [7:0] b,
                                        logic [3:0] m, logic en, logic [3:0] f);
    int sa, sb, sr, n;
    logic [7:0] r, t;
    logic z, c, s, o, lastOut, arith;
    z = f[3]; c = f[2]; s = f[1]; o = f[0];
    r = 8'h00; arith = 1'b0; sr = 0;
    if (!en) return {8'h00, f};
    sa = int'($signed(a));
    sb = int'($signed(b));
    n  = int'(a[2:0]);
    case (m)
      4'h0: begin r = a + b; c = (int'(a) + int'(b)) > 255; sr = sa + sb; arith = 1'b1; end
      4'h1: begin r = a - b; c = (a >= b); sr = sa - sb; arith = 1'b1; end
      4'h7: begin r = b - a; c = (b >= a); sr = sb - sa; arith = 1'b1; end
      4'h8: begin r = b + 8'd1; c = (b == 8'hFF); sr = sb + 1; arith = 1'b1; end
      4'h9: begin r = b - 8'd1; c = (b != 8'h00); sr = sb - 1; arith = 1'b1; end
      4'hF: begin r = 8'h00 - b; c = (b == 8'h00); sr = -sb; arith = 1'b1; end
      4'h2: r = a;
      4'h3: r = b;
      4'h4: begin r = a & b; z = (r == 8'h00); end
      4'h5: begin r = a | b; z = (r == 8'h00); end
      4'h6: begin r = a ^ b; z = (r == 8'h00); end
      4'hA: begin t = b; for (int i = 0; i < n; i++) t = {t[6:0], t[7]}; r = t; end
      4'hB: begin t = b; for (int i = 0; i < n; i++) t = {t[0], t[7:1]}; r = t; end
      default: begin
        t = b; lastOut = 1'b0;
        for (int i = 0; i < n; i++) begin
          if (m == 4'hC) begin lastOut = t[7]; t = {t[6:0], 1'b0}; end
          else if (m == 4'hD) begin lastOut = t[0]; t = {1'b0, t[7:1]}; end
          else begin lastOut = t[0]; t = {t[7], t[7:1]}; end
        end
        r = t;
        if (n != 0) begin z = (t == 8'h00); c = lastOut; end
        if (m == 4'hE) s = t[7];
      end
    endcase
    if (arith) begin
      z = (r == 8'h00);
      s = r[7];
      o = (sr > 127) || (sr < -128);
    end
    return {r, z, c, s, o};
  endfunction

  task automatic drive(logic [7:0] a, logic [7:0] b, logic [3:0] m,
                       logic en, logic [3:0] f);
    item_t it;
    logic [11:0] e;
    @(posedge clk);
    #1;
    accIn = a; operandIn = b; aluMode = m; aluEnable = en; flagsIn = f;
    e = model(a, b, m, en, f);
    it.req = reqOf(m, en, a);
    it.a = a; it.b = b; it.mode = m;
    it.expRes = e[11:4];
    it.expFlags = e[3:0];
    expQ.push_back(it);
  endtask

  // Monitor: compares at the falling edge, away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        compared++;
        if (aluResult !== it.expRes || flagsOut !== it.expFlags) begin
          mismatched++;
          $display("FAIL %s mode=%h a=%h b=%h: got res=%h flags=%b, expected res=%h flags=%b",
                   it.req, it.mode, it.a, it.b, aluResult, flagsOut, it.expRes, it.expFlags);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    accIn = 8'h00; operandIn = 8'h00; aluMode = 4'h0; aluEnable = 1'b0; flagsIn = 4'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R10: disabled state after reset, and ignored mode/operands
    drive(8'h12, 8'h34, 4'h0, 1'b0, 4'b1010);
    drive(8'hFF, 8'h01, 4'hF, 1'b0, 4'b0101);

    // R2: add/sub carry and overflow corners
    drive(8'hFF, 8'h01, 4'h0, 1'b1, 4'b0000);  // zero result, carry
    drive(8'h7F, 8'h01, 4'h0, 1'b1, 4'b0000);  // signed overflow
    drive(8'h05, 8'h05, 4'h1, 1'b1, 4'b0000);  // equal: Z=1, C=1
    drive(8'h80, 8'h01, 4'h1, 1'b1, 4'b0000);  // overflow on subtract
    drive(8'h02, 8'h03, 4'h1, 1'b1, 4'b1111);  // borrow: C=0
    drive(8'h06, 8'h07, 4'h7, 1'b1, 4'b1111);  // operand minus accumulator

    // R3: inc/dec/neg corners
    drive(8'h00, 8'h7F, 4'h8, 1'b1, 4'b0000);
    drive(8'h00, 8'hFF, 4'h8, 1'b1, 4'b0000);
    drive(8'h00, 8'h80, 4'h9, 1'b1, 4'b0000);
    drive(8'h00, 8'h00, 4'h9, 1'b1, 4'b1111);
    drive(8'h00, 8'h80, 4'hF, 1'b1, 4'b0000);
    drive(8'h00, 8'h00, 4'hF, 1'b1, 4'b0000);

    // R4: pass-through keeps every flag
    drive(8'hA5, 8'h3C, 4'h2, 1'b1, 4'b1010);
    drive(8'hA5, 8'h00, 4'h3, 1'b1, 4'b0101);

    // R5: logic ops touch only Z
    drive(8'h03, 8'h04, 4'h4, 1'b1, 4'b0111);
    drive(8'h03, 8'h05, 4'h5, 1'b1, 4'b1000);
    drive(8'h5A, 8'h5A, 4'h6, 1'b1, 4'b0111);

    // R6: rotates
    drive(8'h01, 8'h80, 4'hA, 1'b1, 4'b1111);
    drive(8'h03, 8'h81, 4'hB, 1'b1, 4'b0000);

    // R7: logical shifts, last bit out into C
    drive(8'h01, 8'h80, 4'hC, 1'b1, 4'b0011);
    drive(8'h03, 8'h04, 4'hD, 1'b1, 4'b0011);
    drive(8'h02, 8'h04, 4'hD, 1'b1, 4'b1111);

    // R8: arithmetic shift right
    drive(8'h01, 8'h81, 4'hE, 1'b1, 4'b0001);
    drive(8'h07, 8'h80, 4'hE, 1'b1, 4'b1100);
    drive(8'h03, 8'h04, 4'hE, 1'b1, 4'b0000);

    // R9: zero amount holds Z and C (upper accumulator bits ignored)
    drive(8'hF8, 8'h00, 4'hC, 1'b1, 4'b0100);
    drive(8'h00, 8'h81, 4'hD, 1'b1, 4'b1000);
    drive(8'h08, 8'h80, 4'hE, 1'b1, 4'b1001);

    // R1: flag ordering over a broad sweep of all modes
    for (int k = 0; k < 600; k++) begin
      drive(8'($urandom), 8'($urandom), 4'($urandom), ($urandom % 8) != 0, 4'($urandom));
    end

    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule